// File: doc/BRIEF.md
# Zero-Suppressed Pixel Stream Decoder

This block turns a 16-bit stream of zero-suppressed sensor readout into one hit record per fired pixel. Each frame opens with a 32-bit header split over two words. The word marked with the frame-start strobe carries the upper half: the format code, reserved bits and the chip identity. The next word carries the frame number. After the header the stream interleaves two word kinds. A row header carries the upper nine bits of a row address and a common-mode value. A data word carries the lowest row bit, a column and an ADC sample.

The decoder keeps the latest row header of the current frame. It joins the stored upper row bits with the low bit of each data word, and it presents one registered hit for every accepted data word. Each hit carries the row, column, ADC value, common-mode value, module number, link index and frame number. A frame with any other format code is absorbed without hits. Two sticky flags record a data word seen before its row header and a frame in a foreign format.

Top module: `zsd_decoder`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `hitValid`, `errOrder` and `errFormat` are 0. `inReady` is 0 during reset and 1 from the first clock edge after release.
- R2: A word is accepted when `inValid` and `inReady` are both 1. An accepted word with `inFrameStart`=1 is the upper header half: bits 15:13 hold the format code, bits 12:8 are ignored and bits 7:0 hold the chip identity. The next accepted word is the frame number. Every later hit reports chip bits 7:2 on `hitModuleId`, chip bits 1:0 on `hitLinkIdx` and the frame number on `hitFrameId`.
- R3: In a frame of format code 3'b101, an accepted word with bit 15 = 0 is a row header. Its bits 14:6 become row bits 9:1 and its bits 5:0 become the common-mode value of the following hits.
- R4: In such a frame, an accepted word with bit 15 = 1 is a data word. Its bit 14 is row bit 0, bits 13:8 are the column and bits 7:0 are the ADC value. The hit reports row = {stored row bits 9:1, bit 14}.
- R5: Each data word accepted after a row header in the same frame gives exactly one hit. `hitValid` is 1 for the one cycle after the word's accepting clock edge, and the hit fields are valid in that cycle.
- R6: Consecutive data words reuse the stored row bits 9:1 and common mode until the next row header replaces them.
- R7: A data word accepted in a zero-suppressed frame before any row header of that frame gives no hit and sets `errOrder`. `errOrder` stays 1 until reset.
- R8: A header whose format code is not 3'b101 sets `errFormat`, which stays 1 until reset. All words up to the next frame start are consumed and give no hits.
- R9: Words accepted after reset and before the first frame start are ignored: no hit and no error.
- R10: A frame start always begins a new frame, even in the middle of one. The new frame has no row header until one arrives.
- R11: A cycle with `inValid`=0 changes nothing, whatever `inData` and `inFrameStart` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Decoder accepts words |
| inData | input | 16 | Input stream word |
| inFrameStart | input | 1 | Marks the upper header word of a frame |
| hitValid | output | 1 | Hit record valid this cycle |
| hitRow | output | 10 | Full row address |
| hitCol | output | 6 | Column address |
| hitAdc | output | 8 | ADC sample |
| hitCommonMode | output | 6 | Common-mode value of the row |
| hitModuleId | output | 6 | Module number from chip identity bits 7:2 |
| hitLinkIdx | output | 2 | Readout chip index from chip identity bits 1:0 |
| hitFrameId | output | 16 | Frame number |
| errOrder | output | 1 | Sticky: data word before its row header |
| errFormat | output | 1 | Sticky: frame of a non-decoded format |

## Verification
The assertions assume that `inValid`, `inData` and `inFrameStart` are never unknown after reset. They also assume the upstream side sends the two header words back to back as the first words of a frame, because the bit-field checks read the word accepted in the previous cycle. The stimulus drives every input to a defined value from time zero and changes inputs only on falling edges. It always sends a frame-start word followed directly by its frame number. Stalls and stray words are placed between whole words, never inside the two-word header.

// File: rtl/zsd_pkg.sv
package zsd_pkg;

  // Decoder sequencing states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // no frame seen since reset
    ST_HDR_LO = 2'd1,  // expecting the frame number word
    ST_BODY   = 2'd2,  // decoding row headers and data words
    ST_DROP   = 2'd3   // absorbing a foreign-format frame
  } zsdState_e;

  // Strobes from control to datapath, one per action
  typedef struct packed {
    logic takeHeader;   // latch chip identity from upper header word
    logic takeFrameId;  // latch frame number
    logic takeRow;      // latch row bits and common mode
    logic emitHit;      // register one hit record
    logic raiseOrder;   // set ordering error
    logic raiseFormat;  // set format error
  } zsdStrobe_t;

endpackage

// File: rtl/zsd_ctrl.sv
module zsd_ctrl
  import zsd_pkg::*;
#(
  parameter int TYPE_W  = 3,
  parameter logic [TYPE_W-1:0] ZS_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic              frameStart,
  input  logic              wordIsData,
  input  logic [TYPE_W-1:0] typeField,
  output zsdStrobe_t        strobe,
  output zsdState_e         state
);

  zsdState_e nextState;
  logic      rowKnown, nextRowKnown;
  logic      zsFrame, nextZsFrame;
  logic      typeIsZs;

  assign typeIsZs = (typeField == ZS_CODE);

  always_comb begin
    nextState    = state;
    nextRowKnown = rowKnown;
    nextZsFrame  = zsFrame;
    strobe       = '0;
    if (accept) begin
      if (frameStart) begin
        strobe.takeHeader  = 1'b1;
        strobe.raiseFormat = !typeIsZs;
        nextZsFrame        = typeIsZs;
        nextRowKnown       = 1'b0;
        nextState          = ST_HDR_LO;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_HDR_LO: begin
            strobe.takeFrameId = 1'b1;
            nextState          = zsFrame ? ST_BODY : ST_DROP;
          end
          ST_BODY: begin
            if (!wordIsData) begin
              strobe.takeRow = 1'b1;
              nextRowKnown   = 1'b1;
            end else if (rowKnown) begin
              strobe.emitHit = 1'b1;
            end else begin
              strobe.raiseOrder = 1'b1;
            end
          end
          ST_DROP: ;
          default: nextState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rowKnown <= 1'b0;
      zsFrame  <= 1'b0;
    end else begin
      state    <= nextState;
      rowKnown <= nextRowKnown;
      zsFrame  <= nextZsFrame;
    end
  end

endmodule

// File: rtl/zsd_datapath.sv
module zsd_datapath
  import zsd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 6,
  parameter int ADC_W  = 8,
  parameter int CM_W   = 6,
  parameter int CHIP_W = 8,
  parameter int FID_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  zsdStrobe_t        strobe,
  input  logic [WORD_W-1:0] word,
  output logic              hitValid,
  output logic [ROW_W-1:0]  hitRow,
  output logic [COL_W-1:0]  hitCol,
  output logic [ADC_W-1:0]  hitAdc,
  output logic [CM_W-1:0]   hitCm,
  output logic [CHIP_W-1:0] hitChip,
  output logic [FID_W-1:0]  hitFid,
  output logic              errOrder,
  output logic              errFormat
);

  localparam int ROWHI_W   = ROW_W - 1;
  localparam int ROWHI_LSB = CM_W;
  localparam int COL_LSB   = ADC_W;
  localparam int ROW0_BIT  = ADC_W + COL_W;

  logic [CHIP_W-1:0]  chipReg;
  logic [FID_W-1:0]   fidReg;
  logic [ROWHI_W-1:0] rowHiReg;
  logic [CM_W-1:0]    cmReg;

  // Frame and row context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipReg  <= '0;
      fidReg   <= '0;
      rowHiReg <= '0;
      cmReg    <= '0;
    end else begin
      if (strobe.takeHeader)  chipReg <= word[CHIP_W-1:0];
      if (strobe.takeFrameId) fidReg  <= word[FID_W-1:0];
      if (strobe.takeRow) begin
        rowHiReg <= word[ROWHI_LSB +: ROWHI_W];
        cmReg    <= word[CM_W-1:0];
      end
    end
  end

  // Registered hit record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitRow   <= '0;
      hitCol   <= '0;
      hitAdc   <= '0;
      hitCm    <= '0;
      hitChip  <= '0;
      hitFid   <= '0;
    end else begin
      hitValid <= strobe.emitHit;
      if (strobe.emitHit) begin
        hitRow  <= {rowHiReg, word[ROW0_BIT]};
        hitCol  <= word[COL_LSB +: COL_W];
        hitAdc  <= word[ADC_W-1:0];
        hitCm   <= cmReg;
        hitChip <= chipReg;
        hitFid  <= fidReg;
      end
    end
  end

  // Sticky error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOrder  <= 1'b0;
      errFormat <= 1'b0;
    end else begin
      if (strobe.raiseOrder)  errOrder  <= 1'b1;
      if (strobe.raiseFormat) errFormat <= 1'b1;
    end
  end

endmodule

// File: rtl/zsd_decoder.sv
module zsd_decoder
  import zsd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int TYPE_W  = 3,
  parameter logic [TYPE_W-1:0] ZS_CODE = 3'b101,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 6,
  parameter int ADC_W   = 8,
  parameter int CM_W    = 6,
  parameter int CHIP_W  = 8,
  parameter int LINK_W  = 2,
  parameter int FID_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [WORD_W-1:0]        inData,
  input  logic                     inFrameStart,
  output logic                     hitValid,
  output logic [ROW_W-1:0]         hitRow,
  output logic [COL_W-1:0]         hitCol,
  output logic [ADC_W-1:0]         hitAdc,
  output logic [CM_W-1:0]          hitCommonMode,
  output logic [CHIP_W-LINK_W-1:0] hitModuleId,
  output logic [LINK_W-1:0]        hitLinkIdx,
  output logic [FID_W-1:0]         hitFrameId,
  output logic                     errOrder,
  output logic                     errFormat
);

  localparam int FLAG_BIT = WORD_W - 1;

  logic              readyReg;
  logic              accept;
  zsdStrobe_t        strobe;
  zsdState_e         state;
  logic [CHIP_W-1:0] hitChip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyReg <= 1'b0;
    else       readyReg <= 1'b1;
  end

  assign inReady = readyReg;
  assign accept  = inValid && readyReg;

  zsd_ctrl #(
    .TYPE_W (TYPE_W),
    .ZS_CODE(ZS_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accept    (accept),
    .frameStart(inFrameStart),
    .wordIsData(inData[FLAG_BIT]),
    .typeField (inData[FLAG_BIT -: TYPE_W]),
    .strobe    (strobe),
    .state     (state)
  );

  zsd_datapath #(
    .WORD_W(WORD_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ADC_W (ADC_W),
    .CM_W  (CM_W),
    .CHIP_W(CHIP_W),
    .FID_W (FID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .word     (inData),
    .hitValid (hitValid),
    .hitRow   (hitRow),
    .hitCol   (hitCol),
    .hitAdc   (hitAdc),
    .hitCm    (hitCommonMode),
    .hitChip  (hitChip),
    .hitFid   (hitFrameId),
    .errOrder (errOrder),
    .errFormat(errFormat)
  );

  assign hitModuleId = hitChip[CHIP_W-1:LINK_W];
  assign hitLinkIdx  = hitChip[LINK_W-1:0];

endmodule

// File: rtl/zsd_checker.sv
module zsd_checker
  import zsd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int TYPE_W  = 3,
  parameter logic [TYPE_W-1:0] ZS_CODE = 3'b101,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 6,
  parameter int ADC_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [WORD_W-1:0] inData,
  input logic              inFrameStart,
  input logic              hitValid,
  input logic [ROW_W-1:0]  hitRow,
  input logic [COL_W-1:0]  hitCol,
  input logic [ADC_W-1:0]  hitAdc,
  input logic              errOrder,
  input logic              errFormat,
  input zsdState_e         state
);

  localparam int FLAG_BIT = WORD_W - 1;
  localparam int ROW0_BIT = ADC_W + COL_W;

  logic acc;
  assign acc = inValid && inReady;

  // R5: a hit follows an accepted data word in a decoded frame body
  a_r5_hit_from_data: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(acc && inData[FLAG_BIT] && !inFrameStart && state == ST_BODY));

  // R4: hit fields come from the data word accepted one cycle earlier
  a_r4_fields: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitRow[0] == $past(inData[ROW0_BIT]))
              && (hitCol == $past(inData[ADC_W +: COL_W]))
              && (hitAdc == $past(inData[ADC_W-1:0])));

  // R7: ordering error is sticky
  a_r7_order_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errOrder |=> errOrder);

  // R7: ordering error only follows a data word in a frame body
  a_r7_order_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOrder) |-> $past(acc && inData[FLAG_BIT] && !inFrameStart && state == ST_BODY));

  // R8: format error is sticky
  a_r8_format_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFormat |=> errFormat);

  // R8: format error only follows a foreign-format header word
  a_r8_format_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFormat) |-> $past(acc && inFrameStart && inData[FLAG_BIT -: TYPE_W] != ZS_CODE));

  // R8: no hits while a foreign frame is absorbed
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP) |=> !hitValid);

  // R11: a cycle without a valid word leaves the state alone
  a_r11_stall: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(state) && !hitValid);

endmodule

bind zsd_decoder zsd_checker #(
  .WORD_W (WORD_W),
  .TYPE_W (TYPE_W),
  .ZS_CODE(ZS_CODE),
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .ADC_W  (ADC_W)
) u_zsd_checker (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .inData      (inData),
  .inFrameStart(inFrameStart),
  .hitValid    (hitValid),
  .hitRow      (hitRow),
  .hitCol      (hitCol),
  .hitAdc      (hitAdc),
  .errOrder    (errOrder),
  .errFormat   (errFormat),
  .state       (state)
);

// File: tb/test_zsd_decoder.sv
`timescale 1ns/1ps
module test_zsd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        inFrameStart = 1'b0;
  logic        hitValid;
  logic [9:0]  hitRow;
  logic [5:0]  hitCol;
  logic [7:0]  hitAdc;
  logic [5:0]  hitCommonMode;
  logic [5:0]  hitModuleId;
  logic [1:0]  hitLinkIdx;
  logic [15:0] hitFrameId;
  logic        errOrder;
  logic        errFormat;

  always #2.5 clk = ~clk;

  zsd_decoder i_zsd_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFrameStart(inFrameStart), .hitValid(hitValid),
    .hitRow(hitRow), .hitCol(hitCol), .hitAdc(hitAdc),
    .hitCommonMode(hitCommonMode), .hitModuleId(hitModuleId),
    .hitLinkIdx(hitLinkIdx), .hitFrameId(hitFrameId),
    .errOrder(errOrder), .errFormat(errFormat)
  );

  int checks = 0;
  int errors = 0;
  int hitsSeen = 0;
  logic [53:0] expQ[$];

  // bench-side frame model
  logic       zsMode = 1'b0;
  logic       rowKnown = 1'b0;
  logic [7:0] curChip = '0;
  logic [15:0] curFid = '0;
  logic [8:0] curRowHi = '0;
  logic [5:0] curCm = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [15:0] w, input logic fs);
    @(negedge clk);
    inValid = 1'b1;
    inData = w;
    inFrameStart = fs;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inFrameStart = 1'b0;
    end
  endtask

  task automatic frameHeader(input logic [2:0] ftype, input logic [7:0] chip, input logic [15:0] fid);
    putWord({ftype, 5'b10101, chip}, 1'b1);
    putWord(fid, 1'b0);
    zsMode = (ftype == 3'b101);
    rowKnown = 1'b0;
    curChip = chip;
    curFid = fid;
  endtask

  task automatic rowHeader(input logic [8:0] rh, input logic [5:0] cm);
    putWord({1'b0, rh, cm}, 1'b0);
    if (zsMode) begin
      rowKnown = 1'b1;
      curRowHi = rh;
      curCm = cm;
    end
  endtask

  task automatic dataWord(input logic r0, input logic [5:0] col, input logic [7:0] adc);
    if (zsMode && rowKnown)
      expQ.push_back({curRowHi, r0, col, adc, curCm, curChip, curFid});
    putWord({1'b1, r0, col, adc}, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    inFrameStart = 1'b0;
    expQ.delete();
    zsMode = 1'b0;
    rowKnown = 1'b0;
    repeat (3) @(negedge clk);
    check(inReady == 1'b0, "R1 ready low in reset", inReady, 0);
    check(hitValid == 1'b0 && errOrder == 1'b0 && errFormat == 1'b0,
          "R1 outputs clear in reset", {hitValid, errOrder, errFormat}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);
    check(hitValid == 1'b0 && errOrder == 1'b0 && errFormat == 1'b0,
          "R1 outputs clear after reset", {hitValid, errOrder, errFormat}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && hitValid) begin
      logic [53:0] got;
      hitsSeen++;
      got = {hitRow, hitCol, hitAdc, hitCommonMode, hitModuleId, hitLinkIdx, hitFrameId};
      if (expQ.size() == 0) begin
        check(1'b0, "R5 R8 R9 unexpected hit", {10'd0, got}, 0);
      end else begin
        logic [53:0] exp;
        exp = expQ.pop_front();
        check(got == exp, "R2 R3 R4 R6 hit record", {10'd0, got}, {10'd0, exp});
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    doReset();

    // R9: stray words before any frame start
    base = hitsSeen;
    putWord(16'h0155, 1'b0);
    putWord(16'hC3A5, 1'b0);
    idle(3);
    check(hitsSeen == base, "R9 stray words give no hit", hitsSeen - base, 0);
    check(errOrder == 1'b0 && errFormat == 1'b0, "R9 stray words give no error",
          {errOrder, errFormat}, 0);

    // R3 R4 R6: zero-suppressed frame
    frameHeader(3'b101, 8'h9E, 16'h1234);
    rowHeader(9'h155, 6'h2A);
    dataWord(1'b1, 6'd5, 8'h80);
    dataWord(1'b0, 6'd63, 8'hFF);
    // R11: stalled cycles with data-like content
    @(negedge clk);
    inValid = 1'b0; inData = 16'hFFFF; inFrameStart = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inData = 16'h0000; inFrameStart = 1'b0;
    dataWord(1'b1, 6'd0, 8'h01);
    rowHeader(9'h1FF, 6'h3F);
    dataWord(1'b1, 6'd17, 8'h5A);
    rowHeader(9'h000, 6'h00);
    dataWord(1'b0, 6'd0, 8'h00);
    idle(3);
    check(expQ.size() == 0, "R5 all hits of frame seen", expQ.size(), 0);
    check(errOrder == 1'b0 && errFormat == 1'b0, "R11 R3 clean frame no error",
          {errOrder, errFormat}, 0);

    // R10: restart mid-frame, data before row header
    base = hitsSeen;
    frameHeader(3'b101, 8'h03, 16'hBEEF);
    dataWord(1'b1, 6'd9, 8'h99);
    idle(3);
    check(hitsSeen == base, "R7 R10 no hit before row header", hitsSeen - base, 0);
    check(errOrder == 1'b1, "R7 order error set", errOrder, 1);
    check(errFormat == 1'b0, "R7 format flag untouched", errFormat, 0);
    rowHeader(9'h0A0, 6'h11);
    dataWord(1'b0, 6'd33, 8'h44);
    idle(3);
    check(errOrder == 1'b1, "R7 order error sticky", errOrder, 1);
    check(expQ.size() == 0, "R10 hit after row header", expQ.size(), 0);

    // R8: foreign format frames
    doReset();
    base = hitsSeen;
    frameHeader(3'b000, 8'h55, 16'h0001);
    rowHeader(9'h123, 6'h05);
    dataWord(1'b1, 6'd1, 8'h10);
    dataWord(1'b0, 6'd2, 8'h20);
    idle(2);
    check(errFormat == 1'b1, "R8 format error on raw frame", errFormat, 1);
    check(errOrder == 1'b0, "R8 no order error in dropped frame", errOrder, 0);
    frameHeader(3'b111, 8'h56, 16'h0002);
    dataWord(1'b1, 6'd3, 8'h30);
    idle(2);
    check(hitsSeen == base, "R8 no hits from foreign frames", hitsSeen - base, 0);

    // R8 R2: decoding resumes at the next zero-suppressed frame
    frameHeader(3'b101, 8'hFD, 16'hFFFF);
    rowHeader(9'h0F0, 6'h07);
    dataWord(1'b1, 6'd62, 8'hA5);
    idle(3);
    check(expQ.size() == 0, "R2 hit after foreign frame", expQ.size(), 0);
    check(errFormat == 1'b1, "R8 format error sticky", errFormat, 1);
    check(hitsSeen == base + 1, "R5 one hit per data word", hitsSeen - base, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule